// File: doc/BRIEF.md
# Register-Bus UART with Programmable Bit Divisor

This block is a serial transceiver that a host controls through a small parallel register port. The port has eight byte-wide locations, an active-low select and a direction line. The host programs a 16-bit bit-period divisor as two bytes. Writing a byte to the transmit location sends one frame on the serial output: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receiver watches the serial input for a start bit and takes each data bit at the middle of its bit time. It then places the byte in a receive holding register and raises a pending flag.

The block counts the bit period directly in system clocks, with no oversampling. A status byte reports four conditions: byte received, overrun, framing error and transmitter busy. A single interrupt line is high while a received byte is waiting or a transmission has finished. The host reads an identification byte to find the source of the interrupt. A received byte takes priority over a finished transmission.

Top module: `bus_uart`

## Requirements
- R1: While `rst_n` is low and just after it rises, the block holds the following state: `ser_out` is high, `irq_o` is low, the divisor reads 0, the status byte reads 0x00 and the identification byte reads 0x01.
- R2: A bus write is an access with `bus_sel_n` low and `bus_wr` high. The block captures it exactly once, on the first clock of the access, however long the select stays low. Address 0 loads the divisor low byte and address 1 loads the high byte. Both bytes read back at the same addresses.
- R3: A bus read is an access with `bus_sel_n` low and `bus_wr` low. `bus_rdata` shows the addressed register one clock after the first clock of the access and holds that value until the next read. Addresses 2, 3 and 4 read 0x00.
- R4: One bit lasts P clocks. P is the divisor value, except that a divisor of 0 or 1 gives P = 2.
- R5: A write to address 4 while idle starts a frame on the next clock. The frame is a low start bit, then data bits 0 to 7, then a high stop bit, each lasting P clocks. `ser_out` is high when no frame is being sent.
- R6: A write to address 4 while a frame is in progress has no effect.
- R7: The transmit-complete flag is set as the stop bit ends, 10·P clocks after the frame starts, and it raises `irq_o`. A read of address 7 clears it, but only when it is the source that the read reports.
- R8: The receiver works in these steps:
  - It starts on a high-to-low transition of `ser_in`.
  - It re-checks the line half a bit time later.
  - It samples eight data bits one bit time apart, least significant bit first, then samples the stop bit.
  - The byte is then readable at address 5 and sets status bit 0.
  - A read of address 5 clears status bit 0.
- R9: If `ser_in` is high again at the half-bit check, the receiver drops the start and delivers no byte.
- R10: Status byte at address 6:
  - Bit 0: a received byte is waiting.
  - Bit 1: overrun, meaning a byte arrived while bit 0 was still set. The newer byte replaces the older one.
  - Bit 2: framing error, meaning the stop bit was sampled low.
  - Bit 5: the transmitter is busy.
  - Other bits read 0.
  - A read of address 6 clears bits 1 and 2.
- R11: The identification byte at address 7 is 0x04 while a received byte is waiting, else 0x02 while transmit-complete is set, else 0x01. `irq_o` is high exactly when the received-byte flag or the transmit-complete flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel_n | input | 1 | Active-low register select |
| bus_wr | input | 1 | High selects write, low selects read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt request, active high |
| ser_in | input | 1 | Serial receive line, idles high |
| ser_out | output | 1 | Serial transmit line, idles high |

## Verification
A fault in the transmit bit counter or shift register shows up on `ser_out` within one bit time. Comparing `ser_out` on every clock against a behavioural frame model therefore localises such an error to the wrong bit. A fault in the flag logic shows up on `irq_o` on the clock after the event or bus access that should have changed it, because the interrupt line is compared every clock. A receiver sampling error shows up only when the host reads the byte or the status register back. Those read-backs are checked after every injected frame, including false starts, framing errors and overruns.

// File: rtl/bus_uart_pkg.sv
package bus_uart_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_TX     = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_RX     = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_IID    = 3'd7;

    localparam int ST_READY = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_FRM   = 2;
    localparam int ST_BUSY  = 5;

    localparam logic [DATA_W-1:0] IID_NONE = 8'h01;
    localparam logic [DATA_W-1:0] IID_TX   = 8'h02;
    localparam logic [DATA_W-1:0] IID_RX   = 8'h04;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/bus_uart_access.sv
module bus_uart_access (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic wr_i,
    output logic wr_stb_o,
    output logic rd_stb_o
);
    logic act_q, act_d;
    logic first;

    always_comb begin
        act_d    = !sel_n_i;
        first    = !sel_n_i && !act_q;
        wr_stb_o = first && wr_i;
        rd_stb_o = first && !wr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    // R2: a held write produces one strobe only
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);
    // R3: a held read produces one strobe only
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |=> !rd_stb_o);
endmodule

// File: rtl/bus_uart_tx.sv
module bus_uart_tx
    import bus_uart_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int PW   = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          ser_o
);
    localparam int STOP_IDX = DW + 1;
    localparam int IW       = $clog2(STOP_IDX + 1);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        logic [PW-1:0] cnt;
        logic [DW-1:0] sh;
    } tx_s;

    tx_s tx_q, tx_d;

    always_comb begin
        tx_d   = tx_q;
        done_o = 1'b0;
        if (!tx_q.active) begin
            if (load_i) begin
                tx_d.active = 1'b1;
                tx_d.idx    = '0;
                tx_d.cnt    = period_i - 1'b1;
                tx_d.sh     = data_i;
            end
        end else if (tx_q.cnt != '0) begin
            tx_d.cnt = tx_q.cnt - 1'b1;
        end else if (tx_q.idx == IW'(STOP_IDX)) begin
            tx_d.active = 1'b0;
            done_o      = 1'b1;
        end else begin
            if (tx_q.idx != '0) tx_d.sh = tx_q.sh >> 1;
            tx_d.idx = tx_q.idx + 1'b1;
            tx_d.cnt = period_i - 1'b1;
        end
    end

    always_comb begin
        busy_o = tx_q.active;
        if (!tx_q.active)                     ser_o = 1'b1;
        else if (tx_q.idx == '0)              ser_o = 1'b0;
        else if (tx_q.idx == IW'(STOP_IDX))   ser_o = 1'b1;
        else                                  ser_o = tx_q.sh[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q        <= '0;
        end else begin
            tx_q        <= tx_d;
        end
    end

    // R5: an accepted load drives the start bit on the next clock
    a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> !ser_o);
    // R6: a frame in progress is not cut short by further loads
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
    // R7: completion is reported while the line carries the stop level
    a_r7_done_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ser_o);
endmodule

// File: rtl/bus_uart_rx.sv
module bus_uart_rx
    import bus_uart_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    input  logic          ser_i,
    output logic          valid_o,
    output logic          frame_err_o,
    output logic [DW-1:0] data_o
);
    localparam int NW = $clog2(DW);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        rx_state_e     st;
        logic [PW-1:0] cnt;
        logic [NW-1:0] nbit;
        logic [DW-1:0] sh;
    } rx_s;

    rx_s rx_q, rx_d;

    always_comb begin
        rx_d        = rx_q;
        valid_o     = 1'b0;
        frame_err_o = 1'b0;
        rx_d.s1     = ser_i;
        rx_d.s2     = rx_q.s1;
        rx_d.prev   = rx_q.s2;
        unique case (rx_q.st)
            RX_IDLE: begin
                if (rx_q.prev && !rx_q.s2) begin
                    rx_d.st  = RX_START;
                    rx_d.cnt = (period_i >> 1) - 1'b1;
                end
            end
            RX_START: begin
                if (rx_q.cnt != '0) begin
                    rx_d.cnt = rx_q.cnt - 1'b1;
                end else if (!rx_q.s2) begin
                    rx_d.st   = RX_DATA;
                    rx_d.cnt  = period_i - 1'b1;
                    rx_d.nbit = '0;
                end else begin
                    rx_d.st = RX_IDLE;
                end
            end
            RX_DATA: begin
                if (rx_q.cnt != '0) begin
                    rx_d.cnt = rx_q.cnt - 1'b1;
                end else begin
                    rx_d.sh  = {rx_q.s2, rx_q.sh[DW-1:1]};
                    rx_d.cnt = period_i - 1'b1;
                    if (rx_q.nbit == NW'(DW - 1)) rx_d.st = RX_STOP;
                    else                          rx_d.nbit = rx_q.nbit + 1'b1;
                end
            end
            RX_STOP: begin
                if (rx_q.cnt != '0) begin
                    rx_d.cnt = rx_q.cnt - 1'b1;
                end else begin
                    valid_o     = 1'b1;
                    frame_err_o = !rx_q.s2;
                    rx_d.st     = RX_IDLE;
                end
            end
            default: rx_d.st = RX_IDLE;
        endcase
        data_o = rx_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.s1   <= 1'b1;
            rx_q.s2   <= 1'b1;
            rx_q.prev <= 1'b1;
            rx_q.st   <= RX_IDLE;
        end else begin
            rx_q      <= rx_d;
        end
    end

    // R8: a completed frame is delivered for a single clock
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R9: a start that fails the half-bit check delivers nothing next
    a_r9_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_START && rx_q.cnt == '0 && rx_q.s2) |=> !valid_o);
endmodule

// File: rtl/bus_uart.sv
module bus_uart
    import bus_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              ser_in,
    output logic              ser_out
);
    localparam logic [DIV_W-1:0] MIN_PERIOD = DIV_W'(2);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rxd;
        logic              ready;
        logic              ovr;
        logic              frm;
        logic              txf;
        logic [DATA_W-1:0] rdata;
    } reg_s;

    reg_s r_q, r_d;

    logic              wr_stb, rd_stb, tx_load, tx_busy, tx_done;
    logic              rx_valid, rx_ferr;
    logic [DATA_W-1:0] rx_byte, stat, iid;
    logic [DIV_W-1:0]  period;

    bus_uart_access u_access (
        .clk(clk), .rst_n(rst_n), .sel_n_i(bus_sel_n), .wr_i(bus_wr),
        .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
    );

    bus_uart_tx #(.DW(DATA_W), .PW(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .period_i(period), .load_i(tx_load),
        .data_i(bus_wdata), .busy_o(tx_busy), .done_o(tx_done), .ser_o(ser_out)
    );

    bus_uart_rx #(.DW(DATA_W), .PW(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .period_i(period), .ser_i(ser_in),
        .valid_o(rx_valid), .frame_err_o(rx_ferr), .data_o(rx_byte)
    );

    always_comb begin
        period  = (r_q.div < MIN_PERIOD) ? MIN_PERIOD : r_q.div;
        tx_load = wr_stb && (bus_addr == ADR_TX);

        stat           = '0;
        stat[ST_READY] = r_q.ready;
        stat[ST_OVR]   = r_q.ovr;
        stat[ST_FRM]   = r_q.frm;
        stat[ST_BUSY]  = tx_busy;

        if (r_q.ready)    iid = IID_RX;
        else if (r_q.txf) iid = IID_TX;
        else              iid = IID_NONE;

        r_d = r_q;
        if (wr_stb) begin
            case (bus_addr)
                ADR_DIV_LO: r_d.div[DATA_W-1:0]     = bus_wdata;
                ADR_DIV_HI: r_d.div[DIV_W-1:DATA_W] = bus_wdata;
                default: ;
            endcase
        end
        if (rd_stb) begin
            case (bus_addr)
                ADR_DIV_LO: r_d.rdata = r_q.div[DATA_W-1:0];
                ADR_DIV_HI: r_d.rdata = r_q.div[DIV_W-1:DATA_W];
                ADR_RX: begin
                    r_d.rdata = r_q.rxd;
                    r_d.ready = 1'b0;
                end
                ADR_STAT: begin
                    r_d.rdata = stat;
                    r_d.ovr   = 1'b0;
                    r_d.frm   = 1'b0;
                end
                ADR_IID: begin
                    r_d.rdata = iid;
                    if (!r_q.ready) r_d.txf = 1'b0;
                end
                default: r_d.rdata = '0;
            endcase
        end
        if (tx_done) r_d.txf = 1'b1;
        if (rx_valid) begin
            r_d.rxd = rx_byte;
            if (r_q.ready && !(rd_stb && bus_addr == ADR_RX)) r_d.ovr = 1'b1;
            r_d.ready = 1'b1;
            if (rx_ferr) r_d.frm = 1'b1;
        end

        bus_rdata = r_q.rdata;
        irq_o     = r_q.ready || r_q.txf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R11: a waiting received byte outranks transmit-complete
    a_r11_rx_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && bus_addr == ADR_IID && r_q.ready) |=> (bus_rdata == IID_RX));
    // R7: reporting transmit-complete clears it when nothing new arrives
    a_r7_tx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && bus_addr == ADR_IID && !r_q.ready && !tx_done && !rx_valid) |=> !irq_o);
    // R8: a delivered byte always raises the interrupt
    a_r8_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> irq_o);
endmodule

// File: tb/bus_uart_test.sv
`timescale 1ns/1ps
module bus_uart_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel_n = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;
    logic       ser_in = 1'b1;
    logic       ser_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int bp = 6;
    bit started = 0;
    bit irq_dc = 0;
    bit rx_inject = 0;
    bit done_flag = 0;

    // reference model state
    int   m_div, m_rem, m_bit;
    bit   m_busy, m_txf, m_rdy, m_prev;
    logic [7:0] m_byte;

    always #10 clk = ~clk;

    bus_uart uut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    // behavioural model: frame as a bit list, flags as booleans
    always @(posedge clk) begin
        int  p;
        bit  strobe, rdy_old, set_done;
        if (!rst_n) begin
            m_div = 0; m_busy = 0; m_txf = 0; m_rdy = 0; m_prev = 0;
            m_rem = 0; m_bit = 0; m_byte = '0;
        end else begin
            p        = (m_div < 2) ? 2 : m_div;
            strobe   = !bus_sel_n && !m_prev;
            m_prev   = !bus_sel_n;
            rdy_old  = m_rdy;
            set_done = 0;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_bit++;
                    if (m_bit == 10) begin m_busy = 0; set_done = 1; end
                    else m_rem = p;
                end
            end else if (strobe && bus_wr && bus_addr == 3'd4) begin
                m_busy = 1; m_bit = 0; m_rem = p; m_byte = bus_wdata;
            end
            if (strobe && !bus_wr) begin
                if (bus_addr == 3'd5) m_rdy = 0;
                if (bus_addr == 3'd7 && !rdy_old) m_txf = 0;
            end
            if (strobe && bus_wr && bus_addr == 3'd0) m_div = (m_div & 32'hff00) | int'(bus_wdata);
            if (strobe && bus_wr && bus_addr == 3'd1) m_div = (m_div & 32'h00ff) | (int'(bus_wdata) << 8);
            if (set_done) m_txf = 1;
            if (rx_inject) m_rdy = 1;
        end
    end

    function automatic bit exp_ser();
        if (!m_busy)        return 1'b1;
        else if (m_bit == 0) return 1'b0;
        else if (m_bit == 9) return 1'b1;
        else                 return m_byte[m_bit-1];
    endfunction

    always @(negedge clk) begin
        if (started && rst_n) begin
            check("R5 ser_out vs frame model", int'(ser_out), int'(exp_ser()));
            if (!irq_dc) check("R11 irq_o vs flag model", int'(irq_o), int'(m_rdy | m_txf));
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] v, input int hold);
        @(negedge clk);
        bus_sel_n = 0; bus_wr = 1; bus_addr = a; bus_wdata = v;
        repeat (hold) @(negedge clk);
        bus_sel_n = 1; bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel_n = 0; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        check(tag, int'(bus_rdata), int'(exp));
        repeat (2) @(negedge clk);
        bus_sel_n = 1;
        check({tag, " held"}, int'(bus_rdata), int'(exp));
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stopv);
        irq_dc = 1;
        @(negedge clk);
        ser_in = 0;
        repeat (bp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_in = b[i];
            repeat (bp) @(negedge clk);
        end
        ser_in = stopv;
        repeat (bp) @(negedge clk);
        ser_in = 1;
        repeat (bp) @(negedge clk);
        rx_inject = 1;
        @(negedge clk);
        #1;
        rx_inject = 0;
        irq_dc = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        started = 1;
        check("R1 ser_out idle after reset", int'(ser_out), 1);
        check("R1 irq_o low after reset", int'(irq_o), 0);
        bus_read(3'd6, 8'h00, "R1 status reset");
        bus_read(3'd7, 8'h01, "R1 iid reset");
        bus_read(3'd0, 8'h00, "R1 divisor reset");
        bus_read(3'd3, 8'h00, "R3 unused address");

        // divisor 6
        bus_write(3'd0, 8'h06, 4);
        bus_write(3'd1, 8'h00, 4);
        bus_read(3'd0, 8'h06, "R2 divisor low readback");
        bus_read(3'd4, 8'h00, "R3 tx address reads zero");

        // transmit and completion timing
        bus_write(3'd4, 8'h5A, 4);
        repeat (55) @(negedge clk);
        check("R7 irq before frame end", int'(irq_o), 0);
        @(negedge clk);
        check("R7 irq at frame end", int'(irq_o), 1);
        bus_read(3'd6, 8'h00, "R10 status after tx");
        bus_read(3'd7, 8'h02, "R11 iid tx complete");
        check("R7 irq cleared by iid read", int'(irq_o), 0);
        bus_read(3'd7, 8'h01, "R11 iid none");

        // write while busy is ignored
        bus_write(3'd4, 8'hA5, 4);
        bus_read(3'd6, 8'h20, "R10 busy bit");
        bus_write(3'd4, 8'hFF, 4);
        repeat (70) @(negedge clk);
        bus_read(3'd7, 8'h02, "R6 single completion");

        // long held write starts one frame only
        bus_write(3'd4, 8'h3C, 80);
        check("R2 held write single frame line", int'(ser_out), 1);
        check("R2 held write irq", int'(irq_o), 1);
        bus_read(3'd6, 8'h00, "R2 no second frame");
        bus_read(3'd7, 8'h02, "R2 iid after held write");

        // receive
        send_frame(8'hCE, 1'b1);
        bus_read(3'd6, 8'h01, "R8 ready set");
        check("R8 irq on receive", int'(irq_o), 1);
        bus_read(3'd7, 8'h04, "R11 iid rx");
        bus_read(3'd5, 8'hCE, "R8 received byte");
        bus_read(3'd6, 8'h00, "R8 ready cleared");
        check("R8 irq cleared", int'(irq_o), 0);

        // priority
        bus_write(3'd4, 8'h11, 4);
        repeat (60) @(negedge clk);
        send_frame(8'h81, 1'b1);
        bus_read(3'd7, 8'h04, "R11 rx outranks tx");
        bus_read(3'd5, 8'h81, "R8 second byte");
        bus_read(3'd7, 8'h02, "R11 tx kept through rx report");
        bus_read(3'd7, 8'h01, "R11 all cleared");

        // overrun
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1);
        bus_read(3'd6, 8'h03, "R10 overrun");
        bus_read(3'd5, 8'h34, "R10 newer byte kept");
        bus_read(3'd6, 8'h00, "R10 overrun cleared");

        // framing error
        send_frame(8'h55, 1'b0);
        bus_read(3'd6, 8'h05, "R10 framing error");
        bus_read(3'd6, 8'h01, "R10 framing cleared");
        bus_read(3'd5, 8'h55, "R10 byte with framing error");

        // false start
        @(negedge clk); ser_in = 0;
        @(negedge clk); ser_in = 1;
        repeat (30) @(negedge clk);
        bus_read(3'd6, 8'h00, "R9 glitch ignored");
        check("R9 no irq from glitch", int'(irq_o), 0);

        // long divisor
        bus_write(3'd0, 8'h02, 4);
        bus_write(3'd1, 8'h01, 4);
        bus_read(3'd1, 8'h01, "R2 divisor high readback");
        bus_write(3'd4, 8'h97, 4);
        repeat (253) @(negedge clk);
        check("R4 start bit lasts 258", int'(ser_out), 0);
        @(negedge clk);
        check("R4 first data bit after 258", int'(ser_out), 1);
        repeat (2600) @(negedge clk);
        bus_read(3'd7, 8'h02, "R4 long frame done");

        // divisor zero gives period two
        bus_write(3'd0, 8'h00, 4);
        bus_write(3'd1, 8'h00, 4);
        bus_write(3'd4, 8'h6B, 4);
        repeat (15) @(negedge clk);
        check("R4 min period irq before end", int'(irq_o), 0);
        @(negedge clk);
        check("R4 min period irq at 20", int'(irq_o), 1);
        bus_read(3'd7, 8'h02, "R4 min period iid");

        // odd divisor receive
        bus_write(3'd0, 8'h0B, 4);
        bp = 11;
        send_frame(8'hA3, 1'b1);
        bus_read(3'd5, 8'hA3, "R8 receive at period 11");
        bus_read(3'd6, 8'h00, "R10 clean after read");

        repeat (5) @(negedge clk);
        done_flag = 1;
        finish_run();
    end
endmodule